// File: doc/BRIEF.md
# CAN Fault Confinement Counters

This block keeps the two error counters of a CAN node, one for transmission and one for reception, and derives the node's fault-confinement state from them. The protocol engine drives single-cycle event strobes: a transmit error, a normal receive error, a severe receive error, a successful transmission and a successful reception. The block outputs both counts, the current state, and an alert pulse whenever that state changes.

The counters move in unequal steps. An error raises a count by 8, or by 1 for a normal receive error. A success lowers the matching count by 1, and a count never drops below zero. The receive count saturates at its maximum. If a transmit error would carry the transmit count past its maximum, the node goes bus off. While bus off it ignores all events until a recovery strobe clears both counters.

A test-mode port lets either counter be loaded directly. Outside test mode the counters can only be changed by events.

Top module: `can_fault_conf`

## Requirements
- R1: After the asynchronous reset both counters read 0, `state_o` reads 2'b00 (error active) and `alert_o` is low.
- R2: An accepted `tx_err_i` raises the transmit count by 8, provided the result stays within 255.
- R3: An accepted `rx_err_i` raises the receive count by 1, and an accepted `rx_sev_i` raises it by 8 (`rx_sev_i` wins if both are high). The receive count saturates at 255.
- R4: `tx_ok_i` and `rx_ok_i` lower their counter by 1. A counter at 0 stays at 0. An error strobe for the same counter in the same cycle takes precedence over the success strobe.
- R5: An accepted `rx_ok_i` while the receive count is 128 or more loads the receive count with RX_PRESET (default 120, legal range 119 to 127).
- R6: When the node is not bus off, `state_o` is 2'b01 (error passive) if either count is 128 or more, and 2'b00 (error active) otherwise.
- R7: A `tx_err_i` that would take the transmit count above 255 sets the transmit count to 255 and makes `state_o` 2'b10 (bus off). While bus off, all five event strobes are ignored.
- R8: `recover_i` while bus off clears both counters and returns `state_o` to 2'b00. `recover_i` has no effect when the node is not bus off.
- R9: `alert_o` is high for exactly the one cycle in which `state_o` first shows a new value.
- R10: With `test_en_i` high, `test_wr_tx_i` and `test_wr_rx_i` load `test_data_i` into the transmit and receive counters. A load takes precedence over events, but a bus-off recovery takes precedence over a load. With `test_en_i` low, the write strobes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_err_i | input | 1 | Transmit error event |
| rx_err_i | input | 1 | Receive error event (+1) |
| rx_sev_i | input | 1 | Severe receive error event (+8) |
| tx_ok_i | input | 1 | Successful transmission |
| rx_ok_i | input | 1 | Successful reception |
| recover_i | input | 1 | Bus-off recovery strobe |
| test_en_i | input | 1 | Test mode enable for counter writes |
| test_wr_tx_i | input | 1 | Load transmit counter |
| test_wr_rx_i | input | 1 | Load receive counter |
| test_data_i | input | 8 | Load value |
| tx_cnt_o | output | 8 | Transmit error count |
| rx_cnt_o | output | 8 | Receive error count |
| state_o | output | 2 | 00 active, 01 passive, 10 bus off |
| alert_o | output | 1 | One-cycle pulse on a state change |

## Verification
The bench targets the saturation edges of each counter:
- A receive count at 255 that wraps would fall back to error active.
- A transmit overflow that wraps would not reach bus off.
- A decrement at zero would jump to 255 and go passive.

It also drives errors and successes in the same cycle; a wrong precedence shows up as counts that are off by a step. Success while the receive count is above 127 must hit the preset value, not 127 or 0. Both the 127/128 threshold and the bus-off recovery are checked against the alert pulse, which would otherwise go missing or last too long. Strobes that should be ignored (events while bus off, recovery outside bus off, writes outside test mode) are checked through the counter outputs on the following cycle.

// File: rtl/can_fc_pkg.sv
package can_fc_pkg;

  typedef enum logic [1:0] {
    FC_ACTIVE  = 2'b00,
    FC_PASSIVE = 2'b01,
    FC_BUS_OFF = 2'b10
  } fc_state_e;

endpackage

// File: rtl/can_fc_tx_cnt.sv
module can_fc_tx_cnt #(
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned TX_INC = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             ld_i,
  input  logic [CNT_W-1:0] ld_val_i,
  input  logic             hold_i,
  input  logic             err_i,
  input  logic             ok_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o
);

  localparam logic [CNT_W:0]   INC_X = (CNT_W+1)'(TX_INC);
  localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W:0]   sum;

  assign sum = {1'b0, cnt_q} + INC_X;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)                    cnt_d = '0;
    else if (ld_i)                cnt_d = ld_val_i;
    else if (hold_i)              cnt_d = cnt_q;
    else if (err_i)               cnt_d = sum[CNT_W] ? '1 : sum[CNT_W-1:0];
    else if (ok_i && cnt_q != '0) cnt_d = cnt_q - ONE;
  end

  assign ovf_o = !clr_i && !ld_i && !hold_i && err_i && sum[CNT_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/can_fc_rx_cnt.sv
module can_fc_rx_cnt #(
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned SEV_INC     = 8,
  parameter int unsigned PASSIVE_LIM = 128,
  parameter int unsigned RX_PRESET   = 120
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             ld_i,
  input  logic [CNT_W-1:0] ld_val_i,
  input  logic             hold_i,
  input  logic             err_i,
  input  logic             sev_i,
  input  logic             ok_i,
  output logic [CNT_W-1:0] cnt_o
);

  localparam logic [CNT_W:0]   SEV_X  = (CNT_W+1)'(SEV_INC);
  localparam logic [CNT_W-1:0] LIM    = CNT_W'(PASSIVE_LIM);
  localparam logic [CNT_W-1:0] PRESET = CNT_W'(RX_PRESET);
  localparam logic [CNT_W-1:0] ONE    = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W:0]   sev_sum;

  assign sev_sum = {1'b0, cnt_q} + SEV_X;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)             cnt_d = '0;
    else if (ld_i)         cnt_d = ld_val_i;
    else if (hold_i)       cnt_d = cnt_q;
    else if (sev_i)        cnt_d = sev_sum[CNT_W] ? '1 : sev_sum[CNT_W-1:0];
    else if (err_i)        cnt_d = (cnt_q == '1) ? cnt_q : cnt_q + ONE;
    else if (ok_i) begin
      if (cnt_q >= LIM)    cnt_d = PRESET;
      else if (cnt_q != '0) cnt_d = cnt_q - ONE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/can_fc_state.sv
module can_fc_state
  import can_fc_pkg::*;
#(
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned PASSIVE_LIM = 128
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] tx_cnt_i,
  input  logic [CNT_W-1:0] rx_cnt_i,
  input  logic             ovf_i,
  input  logic             recover_i,
  output logic             bus_off_o,
  output fc_state_e        state_o,
  output logic             alert_o
);

  localparam logic [CNT_W-1:0] LIM = CNT_W'(PASSIVE_LIM);

  logic      boff_q;
  fc_state_e state, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  boff_q <= 1'b0;
    else if (ovf_i)               boff_q <= 1'b1;
    else if (recover_i && boff_q) boff_q <= 1'b0;
  end

  always_comb begin
    if (boff_q)                                   state = FC_BUS_OFF;
    else if (tx_cnt_i >= LIM || rx_cnt_i >= LIM)  state = FC_PASSIVE;
    else                                          state = FC_ACTIVE;
  end

  // previous-state register turns any state change into a one-cycle pulse
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= FC_ACTIVE;
    else         prev_q <= state;
  end

  assign alert_o   = (state != prev_q);
  assign state_o   = state;
  assign bus_off_o = boff_q;

endmodule

// File: rtl/can_fault_conf.sv
module can_fault_conf
  import can_fc_pkg::*;
#(
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned TX_INC      = 8,
  parameter int unsigned RX_SEV_INC  = 8,
  parameter int unsigned PASSIVE_LIM = 128,
  parameter int unsigned RX_PRESET   = 120
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tx_err_i,
  input  logic             rx_err_i,
  input  logic             rx_sev_i,
  input  logic             tx_ok_i,
  input  logic             rx_ok_i,
  input  logic             recover_i,
  input  logic             test_en_i,
  input  logic             test_wr_tx_i,
  input  logic             test_wr_rx_i,
  input  logic [CNT_W-1:0] test_data_i,
  output logic [CNT_W-1:0] tx_cnt_o,
  output logic [CNT_W-1:0] rx_cnt_o,
  output logic [1:0]       state_o,
  output logic             alert_o
);

  logic       bus_off, clr, ld_tx, ld_rx, ovf;
  fc_state_e  state;

  assign clr   = recover_i && bus_off;
  assign ld_tx = test_en_i && test_wr_tx_i;
  assign ld_rx = test_en_i && test_wr_rx_i;

  can_fc_tx_cnt #(.CNT_W(CNT_W), .TX_INC(TX_INC)) u_tx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (clr),
    .ld_i     (ld_tx),
    .ld_val_i (test_data_i),
    .hold_i   (bus_off),
    .err_i    (tx_err_i),
    .ok_i     (tx_ok_i),
    .cnt_o    (tx_cnt_o),
    .ovf_o    (ovf)
  );

  can_fc_rx_cnt #(
    .CNT_W(CNT_W), .SEV_INC(RX_SEV_INC),
    .PASSIVE_LIM(PASSIVE_LIM), .RX_PRESET(RX_PRESET)
  ) u_rx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (clr),
    .ld_i     (ld_rx),
    .ld_val_i (test_data_i),
    .hold_i   (bus_off),
    .err_i    (rx_err_i),
    .sev_i    (rx_sev_i),
    .ok_i     (rx_ok_i),
    .cnt_o    (rx_cnt_o)
  );

  can_fc_state #(.CNT_W(CNT_W), .PASSIVE_LIM(PASSIVE_LIM)) u_state (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tx_cnt_i  (tx_cnt_o),
    .rx_cnt_i  (rx_cnt_o),
    .ovf_i     (ovf),
    .recover_i (recover_i),
    .bus_off_o (bus_off),
    .state_o   (state),
    .alert_o   (alert_o)
  );

  assign state_o = state;

endmodule

// File: rtl/can_fault_conf_chk.sv
module can_fault_conf_chk #(
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned TX_INC      = 8,
  parameter int unsigned PASSIVE_LIM = 128,
  parameter int unsigned RX_PRESET   = 120
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tx_err_i,
  input logic             rx_err_i,
  input logic             rx_sev_i,
  input logic             tx_ok_i,
  input logic             rx_ok_i,
  input logic             recover_i,
  input logic             test_en_i,
  input logic             test_wr_tx_i,
  input logic             test_wr_rx_i,
  input logic [CNT_W-1:0] test_data_i,
  input logic [CNT_W-1:0] tx_cnt_o,
  input logic [CNT_W-1:0] rx_cnt_o,
  input logic [1:0]       state_o,
  input logic             alert_o
);

  localparam logic [CNT_W-1:0] INC    = CNT_W'(TX_INC);
  localparam logic [CNT_W-1:0] LIM    = CNT_W'(PASSIVE_LIM);
  localparam logic [CNT_W-1:0] PRESET = CNT_W'(RX_PRESET);
  localparam logic [CNT_W-1:0] TX_TOP = '1 - INC;

  logic boff, wtx, wrx;
  assign boff = (state_o == 2'b10);
  assign wtx  = test_en_i && test_wr_tx_i;
  assign wrx  = test_en_i && test_wr_rx_i;

  assert_tx_inc_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_err_i && !boff && !wtx && tx_cnt_o <= TX_TOP |=> tx_cnt_o == $past(tx_cnt_o) + INC);

  assert_rx_sat_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_cnt_o == '1 && (rx_err_i || rx_sev_i) && !wrx && !boff |=> rx_cnt_o == '1);

  assert_tx_no_underflow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_cnt_o == '0 && !tx_err_i && !wtx |=> tx_cnt_o == '0);

  assert_rx_preset_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_ok_i && !rx_err_i && !rx_sev_i && !wrx && !boff && rx_cnt_o >= LIM |=> rx_cnt_o == PRESET);

  assert_passive_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !boff |-> ((state_o == 2'b01) == (tx_cnt_o >= LIM || rx_cnt_o >= LIM)));

  assert_boff_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    boff && !recover_i && !wtx && !wrx |=> $stable(tx_cnt_o) && $stable(rx_cnt_o) && boff);

  assert_recover_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    boff && recover_i |=> tx_cnt_o == '0 && rx_cnt_o == '0 && state_o == 2'b00);

  assert_alert_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ##1 alert_o == (state_o != $past(state_o)));

  assert_test_wr_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wtx && !(boff && recover_i) |=> tx_cnt_o == $past(test_data_i));

endmodule

bind can_fault_conf can_fault_conf_chk #(
  .CNT_W(CNT_W), .TX_INC(TX_INC), .PASSIVE_LIM(PASSIVE_LIM), .RX_PRESET(RX_PRESET)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tx_err_i(tx_err_i), .rx_err_i(rx_err_i),
  .rx_sev_i(rx_sev_i), .tx_ok_i(tx_ok_i), .rx_ok_i(rx_ok_i), .recover_i(recover_i),
  .test_en_i(test_en_i), .test_wr_tx_i(test_wr_tx_i), .test_wr_rx_i(test_wr_rx_i),
  .test_data_i(test_data_i), .tx_cnt_o(tx_cnt_o), .rx_cnt_o(rx_cnt_o),
  .state_o(state_o), .alert_o(alert_o)
);

// File: tb/can_fault_conf_tb.sv
`timescale 1ns/1ps
module can_fault_conf_tb;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tx_err_i = 0, rx_err_i = 0, rx_sev_i = 0, tx_ok_i = 0, rx_ok_i = 0;
  logic       recover_i = 0, test_en_i = 0, test_wr_tx_i = 0, test_wr_rx_i = 0;
  logic [7:0] test_data_i = '0;
  logic [7:0] tx_cnt_o, rx_cnt_o;
  logic [1:0] state_o;
  logic       alert_o;

  int n_vec = 0, n_bad = 0;
  int m_tec = 0, m_rec = 0;
  bit m_boff = 0, m_alert = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  can_fault_conf u_dut (.*);

  function automatic int st(input int t, input int r, input bit b);
    if (b) return 2;
    if (t >= 128 || r >= 128) return 1;
    return 0;
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic model();
    int  old_st = st(m_tec, m_rec, m_boff);
    bit  clr = recover_i && m_boff;
    bit  ovf = 0;
    int  t = m_tec, r = m_rec;
    if (clr) t = 0;
    else if (test_en_i && test_wr_tx_i) t = test_data_i;
    else if (m_boff) t = m_tec;
    else if (tx_err_i) begin
      if (m_tec + 8 > 255) begin t = 255; ovf = 1; end
      else t = m_tec + 8;
    end else if (tx_ok_i && m_tec > 0) t = m_tec - 1;
    if (clr) r = 0;
    else if (test_en_i && test_wr_rx_i) r = test_data_i;
    else if (m_boff) r = m_rec;
    else if (rx_sev_i) r = (m_rec + 8 > 255) ? 255 : m_rec + 8;
    else if (rx_err_i) r = (m_rec == 255) ? 255 : m_rec + 1;
    else if (rx_ok_i) r = (m_rec >= 128) ? 120 : ((m_rec > 0) ? m_rec - 1 : 0);
    if (ovf) m_boff = 1;
    else if (clr) m_boff = 0;
    m_tec = t; m_rec = r;
    m_alert = (st(m_tec, m_rec, m_boff) != old_st);
  endtask

  task automatic clr_in();
    {tx_err_i, rx_err_i, rx_sev_i, tx_ok_i, rx_ok_i} = '0;
    {recover_i, test_en_i, test_wr_tx_i, test_wr_rx_i} = '0;
  endtask

  task automatic step(input string tag);
    model();
    @(posedge clk_i);
    #1;
    chk(tag, "tx_cnt", int'(tx_cnt_o), m_tec);
    chk(tag, "rx_cnt", int'(rx_cnt_o), m_rec);
    chk(tag, "state",  int'(state_o), st(m_tec, m_rec, m_boff));
    chk(tag, "alert",  int'(alert_o), int'(m_alert));
    @(negedge clk_i);
    clr_in();
  endtask

  task automatic wr(input bit en, input bit wt, input bit wrr, input int d);
    test_en_i = en; test_wr_tx_i = wt; test_wr_rx_i = wrr; test_data_i = 8'(d);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_c0de));
    repeat (3) @(negedge clk_i);
    #1;
    chk("R1", "tx_cnt", int'(tx_cnt_o), 0);
    chk("R1", "rx_cnt", int'(rx_cnt_o), 0);
    chk("R1", "state",  int'(state_o), 0);
    chk("R1", "alert",  int'(alert_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R3 increments and precedence of severe over normal
    repeat (3) begin rx_err_i = 1; step("R3"); end
    rx_sev_i = 1; rx_err_i = 1; step("R3");
    // R4 decrement, floor at zero, error beats success
    repeat (13) begin rx_ok_i = 1; step("R4"); end
    tx_ok_i = 1; step("R4");
    rx_err_i = 1; rx_ok_i = 1; step("R4");
    // R2 / R6 / R9 crossing the passive threshold
    repeat (16) begin tx_err_i = 1; step("R2"); end
    tx_ok_i = 1; step("R6");
    tx_err_i = 1; step("R9");
    repeat (15) begin tx_ok_i = 1; step("R9"); end
    // R10 writes, ignored without test enable
    wr(0, 1, 1, 200); step("R10");
    wr(1, 0, 1, 250); rx_err_i = 1; step("R10");
    // R3 saturation
    rx_sev_i = 1; step("R3");
    rx_err_i = 1; step("R3");
    // R5 preset
    rx_ok_i = 1; step("R5");
    // R7 bus off entry and event ignore
    wr(1, 1, 0, 250); step("R10");
    tx_err_i = 1; step("R7");
    tx_ok_i = 1; rx_sev_i = 1; tx_err_i = 1; step("R7");
    rx_ok_i = 1; step("R7");
    // R8 recovery, recovery beats write; then ignored when not bus off
    recover_i = 1; wr(1, 1, 0, 77); step("R8");
    rx_err_i = 1; step("R8");
    recover_i = 1; step("R8");

    // random phase
    for (int i = 0; i < 6000; i++) begin
      int bias = ((i / 300) % 2 == 1) ? 70 : 25;
      tx_err_i  = ($urandom_range(99) < bias);
      rx_err_i  = ($urandom_range(99) < 30);
      rx_sev_i  = ($urandom_range(99) < bias / 2);
      tx_ok_i   = ($urandom_range(99) < 50);
      rx_ok_i   = ($urandom_range(99) < 50);
      recover_i = ($urandom_range(99) < 4);
      if ($urandom_range(99) < 4)
        wr($urandom_range(1), $urandom_range(1), $urandom_range(1), $urandom_range(255));
      step("R2/R3/R4/R5/R6/R7/R8/R9/R10");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule